// File: doc/BRIEF.md
# Color Subcarrier and Burst Generator

This block produces the digital color subcarrier for a composite and S-video encoder that runs from a 27 MHz sample clock. A phase accumulator steps by one increment per clock. The standard select input picks the increment, so the accumulator rolls over at either the NTSC or the PAL subcarrier rate. The top ten phase bits address a quarter-wave magnitude table. That one table yields both a signed sine and a signed cosine sample, and the chroma modulator downstream multiplies them by the color-difference signals. At 27 MHz the samples come fast enough that no sin(x)/x compensation is needed after them.

The block takes the pixel counter, line counter, field index and vertical-sync-line flag from the raster timing generator. The subcarrier stays phase-locked to sync because the accumulator reloads a reference phase at one fixed point of the color sequence: pixel 0 of the reference line of field 0. The block also opens the color-burst gate for a fixed number of clocks at a fixed pixel position. For PAL it runs the line-alternating switch and reports the burst angle that belongs to the current line.

Top module: `subcarrier_gen`

## Requirements
- R1: While reset is low, and after its release until the first clock edge, `sin_o`, `cos_o`, `burst_en` and `vsw` are 0, and `burst_ang` shows the NTSC value when `pal` is 0.
- R2: At each clock edge without a reference hit, the phase advances by round(f_sc / 27e6 × 2^32) modulo 2^32. f_sc is 3 579 545 Hz when `pal`=0 and 4 433 619 Hz when `pal`=1.
- R3: An edge that samples `field_idx`=0, `line_cnt`=REF_LINE (default 4) and `pix_cnt`=0 loads the phase with REF_PHASE (default 0) and does not add the increment. The same line and pixel in any other field only advances the phase.
- R4: After each edge, `sin_o` equals round(511 × sin(2π(p+0.5)/1024)), where p is bits 31..22 of the phase held before that edge. It is a 10-bit two's-complement value.
- R5: After each edge, `cos_o` equals round(511 × cos(2π(p+0.5)/1024)), with the same p as R4.
- R6: `burst_en` rises only after an edge that samples `pix_cnt`=BURST_START (default 143).
- R7: Once open, `burst_en` stays high for round(N × 27e6 / f_sc) consecutive clocks. N is 9 for NTSC, giving 68 clocks, and 10 for PAL, giving 61 clocks.
- R8: The gate does not open on a line where `vs_line` is 1 when `pix_cnt`=BURST_START is sampled.
- R9: With `pal`=1, `vsw` inverts at every edge that samples `pix_cnt`=0, except at a reference hit, where it is cleared. With `pal`=0, `vsw` is 0 after every edge.
- R10: `burst_ang` gives the burst angle in steps of 360/256 degrees. It is 128 (180°) for NTSC. For PAL it is 96 (135°) when `vsw`=0 and 160 (225°) when `vsw`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pal | input | 1 | Standard select: 0 NTSC, 1 PAL |
| pix_cnt | input | 11 | Pixel position within the line, 0 at the sync leading edge |
| line_cnt | input | 10 | Line number within the field |
| field_idx | input | 3 | Field number within the color sequence |
| vs_line | input | 1 | Current line lies in the vertical sync interval |
| sin_o | output | 10 | Signed subcarrier sine sample |
| cos_o | output | 10 | Signed subcarrier cosine sample |
| burst_en | output | 1 | Color-burst gate |
| vsw | output | 1 | PAL line-alternation switch |
| burst_ang | output | 8 | Burst angle for the current line, 360/256 degrees per step |

## Verification
Some properties are checked on every cycle. The phase either steps by the selected increment or reloads on a reference hit. The burst gate rises only at the start pixel, stays closed on sync lines, and closes after exactly the standard's clock count. The line switch inverts at each line start in PAL and holds at 0 in NTSC. The bench's scenarios cover what depends on values. Sine and cosine amplitudes are checked against a trigonometric model at chosen phase distances from the reference point. The bench shows that a reference line in a non-zero field leaves the phase running, and that the burst angle follows the switch across consecutive PAL lines.

// File: rtl/subcarrier_gen.sv
module subcarrier_gen #(
  parameter real CLK_HZ      = 27.0e6,
  parameter real FSC_NTSC_HZ = 3579545.0,
  parameter real FSC_PAL_HZ  = 4433619.0,
  parameter int  ACC_W       = 32,
  parameter int  LUT_AW      = 8,
  parameter int  OUT_W       = 10,
  parameter int  PIX_W       = 11,
  parameter int  LINE_W      = 10,
  parameter int  FLD_W       = 3,
  parameter int  CYC_NTSC    = 9,
  parameter int  CYC_PAL     = 10,
  parameter int  BURST_START = 143,
  parameter int  REF_LINE    = 4,
  parameter logic [ACC_W-1:0] REF_PHASE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pal,
  input  logic [PIX_W-1:0]        pix_cnt,
  input  logic [LINE_W-1:0]       line_cnt,
  input  logic [FLD_W-1:0]        field_idx,
  input  logic                    vs_line,
  output logic signed [OUT_W-1:0] sin_o,
  output logic signed [OUT_W-1:0] cos_o,
  output logic                    burst_en,
  output logic                    vsw,
  output logic [7:0]              burst_ang
);
  localparam real SCALE  = 2.0 ** ACC_W;
  localparam logic [ACC_W-1:0] INC_N = ACC_W'($rtoi(FSC_NTSC_HZ / CLK_HZ * SCALE + 0.5));
  localparam logic [ACC_W-1:0] INC_P = ACC_W'($rtoi(FSC_PAL_HZ / CLK_HZ * SCALE + 0.5));
  localparam int  BLEN_N = $rtoi(CYC_NTSC * CLK_HZ / FSC_NTSC_HZ + 0.5);
  localparam int  BLEN_P = $rtoi(CYC_PAL * CLK_HZ / FSC_PAL_HZ + 0.5);
  localparam int  BCNT_W = $clog2((BLEN_N > BLEN_P ? BLEN_N : BLEN_P) + 1);
  localparam int  IDX_W  = LUT_AW + 2;
  localparam int  QN     = 1 << LUT_AW;
  localparam int  AMP    = (1 << (OUT_W - 1)) - 1;
  localparam real PI     = 3.14159265358979;

  logic [OUT_W-2:0] qtab [QN];
  for (genvar i = 0; i < QN; i++) begin : g_tab
    localparam int V = $rtoi(AMP * $sin((i + 0.5) * PI / (2.0 * QN)) + 0.5);
    assign qtab[i] = (OUT_W-1)'(V);
  end

  logic [ACC_W-1:0]  acc, inc;
  logic              ref_hit;
  logic [IDX_W-1:0]  idx_s, idx_c;
  logic [LUT_AW-1:0] js, jc;
  logic [OUT_W-2:0]  ms, mc;
  logic signed [OUT_W-1:0] sin_nx, cos_nx;
  logic [BCNT_W-1:0] bcnt, blen;

  assign inc     = pal ? INC_P : INC_N;
  assign ref_hit = (field_idx == '0) && (line_cnt == LINE_W'(REF_LINE)) && (pix_cnt == '0);
  assign blen    = pal ? BCNT_W'(BLEN_P - 1) : BCNT_W'(BLEN_N - 1);

  assign idx_s  = acc[ACC_W-1 -: IDX_W];
  assign idx_c  = idx_s + IDX_W'(QN);
  assign js     = idx_s[LUT_AW] ? ~idx_s[LUT_AW-1:0] : idx_s[LUT_AW-1:0];
  assign jc     = idx_c[LUT_AW] ? ~idx_c[LUT_AW-1:0] : idx_c[LUT_AW-1:0];
  assign ms     = qtab[js];
  assign mc     = qtab[jc];
  assign sin_nx = idx_s[IDX_W-1] ? -signed'({1'b0, ms}) : signed'({1'b0, ms});
  assign cos_nx = idx_c[IDX_W-1] ? -signed'({1'b0, mc}) : signed'({1'b0, mc});

  assign burst_ang = !pal ? 8'd128 : (vsw ? 8'd160 : 8'd96);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc      <= '0;
      sin_o    <= '0;
      cos_o    <= '0;
      burst_en <= 1'b0;
      bcnt     <= '0;
      vsw      <= 1'b0;
    end else begin
      acc   <= ref_hit ? REF_PHASE : acc + inc;
      sin_o <= sin_nx;
      cos_o <= cos_nx;
      if (burst_en) begin
        if (bcnt == '0) burst_en <= 1'b0;
        else            bcnt     <= bcnt - 1'b1;
      end else if (pix_cnt == PIX_W'(BURST_START) && !vs_line) begin
        burst_en <= 1'b1;
        bcnt     <= blen;
      end
      if (!pal || ref_hit)     vsw <= 1'b0;
      else if (pix_cnt == '0)  vsw <= ~vsw;
    end
  end
endmodule

// File: rtl/subcarrier_gen_checker.sv
module subcarrier_gen_checker #(
  parameter int ACC_W = 32,
  parameter int PIX_W = 11,
  parameter int BURST_START = 143,
  parameter int LEN_N = 68,
  parameter int LEN_P = 61,
  parameter logic [ACC_W-1:0] REF_PHASE = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pal,
  input logic [PIX_W-1:0] pix_cnt,
  input logic             vs_line,
  input logic [ACC_W-1:0] acc,
  input logic [ACC_W-1:0] inc,
  input logic             ref_hit,
  input logic             burst_en,
  input logic             vsw
);
  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else        hi_cnt <= burst_en ? hi_cnt + 1'b1 : '0;
  end

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ref_hit)) |-> acc == $past(acc) + $past(inc));

  assert_phase_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> acc == REF_PHASE);

  assert_burst_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_en) |-> $past(pix_cnt) == PIX_W'(BURST_START));

  assert_burst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(burst_en) |-> hi_cnt == 16'(pal ? LEN_P : LEN_N));

  assert_burst_vsync_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_cnt == PIX_W'(BURST_START) && vs_line && !burst_en) |=> !burst_en);

  assert_vsw_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pal && !ref_hit && pix_cnt == '0) |=> vsw != $past(vsw));

  assert_vsw_ntsc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pal |=> !vsw);
endmodule

bind subcarrier_gen subcarrier_gen_checker #(
  .ACC_W(ACC_W), .PIX_W(PIX_W), .BURST_START(BURST_START),
  .LEN_N(BLEN_N), .LEN_P(BLEN_P), .REF_PHASE(REF_PHASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pal(pal), .pix_cnt(pix_cnt), .vs_line(vs_line),
  .acc(acc), .inc(inc), .ref_hit(ref_hit), .burst_en(burst_en), .vsw(vsw)
);

// File: tb/subcarrier_gen_bench.sv
module subcarrier_gen_bench;
  localparam int  CLK_PERIOD = 38;
  localparam int  LINE_LEN   = 300;
  localparam int  REF_LINE   = 4;
  localparam int  BSTART     = 143;
  localparam real PI         = 3.14159265358979;
  localparam int  NV         = 8;
  localparam int  TV_PAL [NV] = '{0, 0, 0, 0, 1, 1, 1, 1};
  localparam int  TV_N   [NV] = '{1, 2, 5, 333, 1, 3, 77, 1000};

  logic clk = 0, rst_n = 0, pal = 0, vs_line = 0;
  logic [10:0] pix_cnt = '0;
  logic [9:0]  line_cnt = '0;
  logic [2:0]  field_idx = 3'd1;
  logic signed [9:0] sin_o, cos_o;
  logic burst_en, vsw;
  logic [7:0] burst_ang;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subcarrier_gen u_subcarrier_gen (
    .clk(clk), .rst_n(rst_n), .pal(pal), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
    .field_idx(field_idx), .vs_line(vs_line), .sin_o(sin_o), .cos_o(cos_o),
    .burst_en(burst_en), .vsw(vsw), .burst_ang(burst_ang));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint step_of(input bit p);
    real f;
    f = p ? 4433619.0 : 3579545.0;
    return longint'($floor(f / 27.0e6 * 4294967296.0 + 0.5));
  endfunction

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check_wave(input longint ph, input string tag);
    int  p;
    real a;
    int  es, ec;
    p  = int'((ph & 64'hFFFF_FFFF) >> 22);
    a  = 2.0 * PI * (p + 0.5) / 1024.0;
    es = rnd(511.0 * $sin(a));
    ec = rnd(511.0 * $cos(a));
    chk((int'(sin_o) - es <= 1) && (es - int'(sin_o) <= 1), {tag, " R4 sine"}, sin_o, es);
    chk((int'(cos_o) - ec <= 1) && (ec - int'(cos_o) <= 1), {tag, " R5 cosine"}, cos_o, ec);
  endtask

  task automatic hit_ref(input bit p);
    pal = p; field_idx = 3'd0; line_cnt = 10'(REF_LINE); pix_cnt = '0; vs_line = 0;
    tick();
    field_idx = 3'd1; line_cnt = 10'(REF_LINE + 1); pix_cnt = 11'd5;
  endtask

  task automatic run_line(input bit p, input bit vsl, output int first, output int cnt,
                          output bit sw, output int ang);
    first = -1; cnt = 0; sw = 0; ang = 0;
    pal = p; vs_line = vsl; field_idx = 3'd3; line_cnt = 10'd20;
    for (int x = 0; x < LINE_LEN; x++) begin
      pix_cnt = 11'(x);
      tick();
      if (x == 0) begin sw = vsw; ang = burst_ang; end
      if (burst_en) begin
        if (first < 0) first = x;
        cnt++;
      end
    end
    vs_line = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first, cnt, ang, ang2;
    bit sw, sw2;
    longint ph;
    repeat (3) @(negedge clk);
    chk(sin_o == 0, "R1 sin in reset", sin_o, 0);
    chk(cos_o == 0, "R1 cos in reset", cos_o, 0);
    chk(burst_en == 0, "R1 burst in reset", burst_en, 0);
    chk(vsw == 0, "R1 vsw in reset", vsw, 0);
    chk(burst_ang == 128, "R1 angle in reset", burst_ang, 128);
    rst_n = 1;

    // table walk: phase distance from the reference point (R2, R3, R4, R5)
    for (int k = 0; k < NV; k++) begin
      hit_ref(TV_PAL[k] != 0);
      repeat (TV_N[k]) tick();
      ph = longint'(TV_N[k] - 1) * step_of(TV_PAL[k] != 0);
      check_wave(ph, $sformatf("R2 R3 vec%0d", k));
    end

    // R3: reference line in a non-zero field must not reload
    hit_ref(1'b0);
    repeat (3) tick();
    field_idx = 3'd2; line_cnt = 10'(REF_LINE); pix_cnt = '0;
    tick();
    field_idx = 3'd1; line_cnt = 10'(REF_LINE + 1); pix_cnt = 11'd5;
    repeat (4) tick();
    check_wave(longint'(7) * step_of(1'b0), "R3 other field");

    // NTSC line: burst position, length, switch, angle
    run_line(1'b0, 1'b0, first, cnt, sw, ang);
    chk(first == BSTART, "R6 NTSC burst start", first, BSTART);
    chk(cnt == 68, "R7 NTSC burst length", cnt, 68);
    chk(sw == 0, "R9 NTSC vsw", sw, 0);
    chk(ang == 128, "R10 NTSC angle", ang, 128);

    // PAL lines after a reference hit: switch cleared then alternating
    hit_ref(1'b1);
    chk(vsw == 0, "R9 vsw cleared at reference", vsw, 0);
    run_line(1'b1, 1'b0, first, cnt, sw, ang);
    chk(first == BSTART, "R6 PAL burst start", first, BSTART);
    chk(cnt == 61, "R7 PAL burst length", cnt, 61);
    chk(sw == 1, "R9 PAL first line vsw", sw, 1);
    chk(ang == 160, "R10 PAL angle vsw=1", ang, 160);
    run_line(1'b1, 1'b0, first, cnt, sw2, ang2);
    chk(sw2 != sw, "R9 PAL vsw alternates", sw2, !sw);
    chk(ang2 == 96, "R10 PAL angle vsw=0", ang2, 96);

    // R8: vertical sync lines carry no burst
    run_line(1'b1, 1'b1, first, cnt, sw, ang);
    chk(cnt == 0, "R8 PAL vsync line burst", cnt, 0);
    run_line(1'b0, 1'b1, first, cnt, sw, ang);
    chk(cnt == 0, "R8 NTSC vsync line burst", cnt, 0);

    // R1: reset mid-run clears outputs
    pal = 1; rst_n = 0;
    @(negedge clk);
    chk(sin_o == 0 && cos_o == 0, "R1 wave after reset", sin_o, 0);
    chk(vsw == 0 && burst_en == 0, "R1 gate after reset", vsw, 0);
    chk(burst_ang == 96, "R10 PAL angle after reset", burst_ang, 96);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule